// File: doc/BRIEF.md
# DMA Throughput Statistics Counters

This block watches two activity signals of a DMA data path and turns them into throughput figures. The first figure is how long the data writer sits stalled until the DMA engine acknowledges that buffered data has reached host memory. The second is the spacing between successive DMA descriptors issued by the descriptor logic. For each figure the block measures every interval in clock cycles. Within a sampling period it keeps the largest interval, the sum of all intervals and the number of intervals. Software can divide the sum by the count to get a mean.

A free-running period timer closes a sampling period every `PERIOD` clock cycles. The default is 250,000,000 cycles, which is one second at a 4 ns clock. At that boundary the live maximum, sum and count of each figure are copied into readout registers together with the most recent interval, and the live figures restart from zero. An interval that completes in the boundary cycle itself still counts in the period being closed. The readout registers then hold steady for a whole period, so a slow register bus can read them at leisure.

Top module: `dma_tput_stats`

## Requirements
- R1: While `stall_i` is high the stall interval grows by one per cycle. The first cycle with `stall_i` low after a high run completes a stall interval whose value is the number of high cycles in that run.
- R2: A one-cycle high on `desc_i` marks a descriptor. Each descriptor after the first one since reset completes a gap interval equal to the number of clock cycles since the previous descriptor, so descriptors in adjacent cycles give 1. The first descriptor after reset completes no interval.
- R3: An interval value saturates at 2^CNT_W-1 instead of wrapping, however long the stall or gap lasts.
- R4: The `*_max_o` output of a figure equals the largest interval completed in the latest closed period, or 0 if none completed.
- R5: `*_sum_o` equals the sum and `*_cnt_o` equals the number of intervals completed in the latest closed period.
- R6: A period closes at the clock edge ending cycle PERIOD-1 after reset release, and every PERIOD cycles after that. `snap_o` is high for exactly the one cycle that follows each close, and all readout outputs change only at a close.
- R7: After a close the live maximum, sum and count start from zero. An interval that completes in the closing cycle is included in the closed period and not in the next one.
- R8: `*_last_o` takes, at each close, the most recent interval completed since reset, including one that completes in the closing cycle. The value is kept through periods in which no interval completes.
- R9: While `rst` is high at a clock edge, all outputs return to 0 and no interval is in progress.
- R10: An interval that spans a period boundary counts with its full length in the period in which it completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting clock |
| rst | input | 1 | Synchronous active-high reset |
| stall_i | input | 1 | Writer is waiting for a DMA acknowledge |
| desc_i | input | 1 | One-cycle descriptor strobe |
| snap_o | output | 1 | Readout registers were just refreshed |
| stall_last_o | output | CNT_W | Most recent stall interval at last close |
| stall_max_o | output | CNT_W | Largest stall interval of the closed period |
| stall_sum_o | output | $clog2(PERIOD)+CNT_W | Sum of stall intervals of the closed period |
| stall_cnt_o | output | $clog2(PERIOD+1) | Number of stall intervals of the closed period |
| gap_last_o | output | CNT_W | Most recent descriptor gap at last close |
| gap_max_o | output | CNT_W | Largest descriptor gap of the closed period |
| gap_sum_o | output | $clog2(PERIOD)+CNT_W | Sum of descriptor gaps of the closed period |
| gap_cnt_o | output | $clog2(PERIOD+1) | Number of descriptor gaps of the closed period |

## Verification
The hardest situation to reach is an interval that finishes in the very cycle a period closes. In that case the live figures are being cleared and updated on the same edge. The bench keeps its own copy of the period count, counts cycles up to three before a boundary, and then holds `stall_i` high so that it falls, and fires `desc_i`, exactly in the closing cycle. It also runs stalls and gaps that cross a boundary or go past the saturation limit, and uses a short period with a narrow counter so that both cases happen within a few hundred cycles.

// File: rtl/tps_pkg.sv
package tps_pkg;

    // how an interval source is interpreted
    typedef enum logic {
        IV_LEVEL = 1'b0,   // interval = length of a high run
        IV_PULSE = 1'b1    // interval = spacing between strobes
    } iv_mode_e;

    localparam int unsigned NUM_CH   = 2;
    localparam int unsigned CH_STALL = 0;
    localparam int unsigned CH_GAP   = 1;

    // increment that sticks at lim
    function automatic logic [63:0] sat_inc(input logic [63:0] v, input logic [63:0] lim);
        return (v >= lim) ? lim : v + 64'd1;
    endfunction

    function automatic logic [63:0] umax(input logic [63:0] a, input logic [63:0] b);
        return (a >= b) ? a : b;
    endfunction

endpackage

// File: rtl/tps_period_timer.sv
module tps_period_timer #(
    parameter int unsigned PERIOD = 250_000_000
) (
    input  logic clk,
    input  logic rst,
    output logic snap_o,
    output logic fresh_o
);
    localparam int unsigned TW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam logic [TW-1:0] LAST_TICK = TW'(PERIOD - 1);

    logic [TW-1:0] tick_q;

    assign snap_o = (tick_q == LAST_TICK);

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_q  <= '0;
            fresh_o <= 1'b0;
        end else begin
            tick_q  <= snap_o ? '0 : tick_q + TW'(1);
            fresh_o <= snap_o;
        end
    end

    AST_TICK_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        tick_q <= LAST_TICK); // R6

    AST_SNAP_SPACED: assert property (@(posedge clk) disable iff (rst)
        snap_o |=> !snap_o); // R6

    AST_FRESH_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        snap_o |=> fresh_o); // R6

endmodule

// File: rtl/tps_interval.sv
module tps_interval #(
    parameter tps_pkg::iv_mode_e MODE  = tps_pkg::IV_LEVEL,
    parameter int unsigned       CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_i,
    output logic             ev_o,
    output logic [CNT_W-1:0] val_o
);
    import tps_pkg::*;

    localparam logic [CNT_W-1:0] LIM = '1;

    generate
        if (MODE == IV_LEVEL) begin : g_level
            logic [CNT_W-1:0] run_q;
            logic             busy_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    run_q  <= '0;
                    busy_q <= 1'b0;
                end else begin
                    busy_q <= in_i;
                    if (in_i)
                        run_q <= CNT_W'(sat_inc(64'(run_q), 64'(LIM)));
                    else
                        run_q <= '0;
                end
            end

            assign ev_o  = busy_q && !in_i;
            assign val_o = run_q;

            AST_RUN_GROWS: assert property (@(posedge clk) disable iff (rst)
                (in_i && run_q != LIM) |=> (run_q == $past(run_q) + CNT_W'(1))); // R1

            AST_RUN_SAT: assert property (@(posedge clk) disable iff (rst)
                (in_i && run_q == LIM) |=> (run_q == LIM)); // R3

            AST_RUN_ENDS: assert property (@(posedge clk) disable iff (rst)
                ev_o |=> !ev_o); // R1
        end else begin : g_pulse
            logic [CNT_W-1:0] gap_q;
            logic             armed_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    gap_q   <= '0;
                    armed_q <= 1'b0;
                end else if (in_i) begin
                    gap_q   <= CNT_W'(1);
                    armed_q <= 1'b1;
                end else if (armed_q) begin
                    gap_q <= CNT_W'(sat_inc(64'(gap_q), 64'(LIM)));
                end
            end

            assign ev_o  = in_i && armed_q;
            assign val_o = gap_q;

            AST_GAP_RESTART: assert property (@(posedge clk) disable iff (rst)
                in_i |=> (gap_q == CNT_W'(1))); // R2

            AST_GAP_SAT: assert property (@(posedge clk) disable iff (rst)
                (armed_q && !in_i && gap_q == LIM) |=> (gap_q == LIM)); // R3

            AST_GAP_NONZERO: assert property (@(posedge clk) disable iff (rst)
                ev_o |-> (gap_q != '0)); // R2
        end
    endgenerate

endmodule

// File: rtl/tps_accum.sv
module tps_accum #(
    parameter int unsigned PERIOD = 250_000_000,
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned SUM_W  = 44,
    parameter int unsigned EV_W   = 28
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ev_i,
    input  logic [CNT_W-1:0] val_i,
    input  logic             snap_i,
    output logic [CNT_W-1:0] last_o,
    output logic [CNT_W-1:0] max_o,
    output logic [SUM_W-1:0] sum_o,
    output logic [EV_W-1:0]  cnt_o
);
    import tps_pkg::*;

    typedef struct packed {
        logic [CNT_W-1:0] mx;
        logic [SUM_W-1:0] sum;
        logic [EV_W-1:0]  n;
    } stat_t;

    stat_t            live_q, live_nxt, ro_q;
    logic [CNT_W-1:0] last_q, last_nxt, ro_last_q;

    always_comb begin
        live_nxt = live_q;
        last_nxt = last_q;
        if (ev_i) begin
            live_nxt.mx  = CNT_W'(umax(64'(live_q.mx), 64'(val_i)));
            live_nxt.sum = live_q.sum + SUM_W'(val_i);
            live_nxt.n   = live_q.n + EV_W'(1);
            last_nxt     = val_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q    <= '0;
            ro_q      <= '0;
            last_q    <= '0;
            ro_last_q <= '0;
        end else begin
            last_q <= last_nxt;
            if (snap_i) begin
                ro_q      <= live_nxt;
                ro_last_q <= last_nxt;
                live_q    <= '0;
            end else begin
                live_q <= live_nxt;
            end
        end
    end

    assign last_o = ro_last_q;
    assign max_o  = ro_q.mx;
    assign sum_o  = ro_q.sum;
    assign cnt_o  = ro_q.n;

    AST_SNAP_CLEARS: assert property (@(posedge clk) disable iff (rst)
        snap_i |=> (live_q == '0)); // R7

    AST_MAX_COVERS: assert property (@(posedge clk) disable iff (rst)
        (ev_i && !snap_i) |=> (live_q.mx >= $past(val_i))); // R4

    AST_SUM_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        !snap_i |=> (live_q.sum >= $past(live_q.sum))); // R5

    AST_RO_STABLE: assert property (@(posedge clk) disable iff (rst)
        !snap_i |=> ($stable(ro_q) && $stable(ro_last_q))); // R6

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        32'(ro_q.n) <= PERIOD); // R5

endmodule

// File: rtl/dma_tput_stats.sv
module dma_tput_stats #(
    parameter int unsigned PERIOD = 250_000_000,
    parameter int unsigned CNT_W  = 16,
    localparam int unsigned SUM_W = $clog2(PERIOD) + CNT_W,
    localparam int unsigned EV_W  = $clog2(PERIOD + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             stall_i,
    input  logic             desc_i,
    output logic             snap_o,
    output logic [CNT_W-1:0] stall_last_o,
    output logic [CNT_W-1:0] stall_max_o,
    output logic [SUM_W-1:0] stall_sum_o,
    output logic [EV_W-1:0]  stall_cnt_o,
    output logic [CNT_W-1:0] gap_last_o,
    output logic [CNT_W-1:0] gap_max_o,
    output logic [SUM_W-1:0] gap_sum_o,
    output logic [EV_W-1:0]  gap_cnt_o
);
    import tps_pkg::*;

    logic             snap;
    logic [NUM_CH-1:0] src;
    logic [NUM_CH-1:0] ev;
    logic [CNT_W-1:0] val  [NUM_CH];
    logic [CNT_W-1:0] last [NUM_CH];
    logic [CNT_W-1:0] mx   [NUM_CH];
    logic [SUM_W-1:0] sum  [NUM_CH];
    logic [EV_W-1:0]  n    [NUM_CH];

    assign src[CH_STALL] = stall_i;
    assign src[CH_GAP]   = desc_i;

    tps_period_timer #(.PERIOD(PERIOD)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .snap_o  (snap),
        .fresh_o (snap_o)
    );

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            tps_interval #(
                .MODE  ((c == CH_STALL) ? IV_LEVEL : IV_PULSE),
                .CNT_W (CNT_W)
            ) u_iv (
                .clk   (clk),
                .rst   (rst),
                .in_i  (src[c]),
                .ev_o  (ev[c]),
                .val_o (val[c])
            );

            tps_accum #(
                .PERIOD (PERIOD),
                .CNT_W  (CNT_W),
                .SUM_W  (SUM_W),
                .EV_W   (EV_W)
            ) u_acc (
                .clk    (clk),
                .rst    (rst),
                .ev_i   (ev[c]),
                .val_i  (val[c]),
                .snap_i (snap),
                .last_o (last[c]),
                .max_o  (mx[c]),
                .sum_o  (sum[c]),
                .cnt_o  (n[c])
            );
        end
    endgenerate

    assign stall_last_o = last[CH_STALL];
    assign stall_max_o  = mx[CH_STALL];
    assign stall_sum_o  = sum[CH_STALL];
    assign stall_cnt_o  = n[CH_STALL];
    assign gap_last_o   = last[CH_GAP];
    assign gap_max_o    = mx[CH_GAP];
    assign gap_sum_o    = sum[CH_GAP];
    assign gap_cnt_o    = n[CH_GAP];

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!snap_o && stall_cnt_o == '0 && gap_cnt_o == '0)); // R9

    AST_MAX_LE_SUM: assert property (@(posedge clk) disable iff (rst)
        (SUM_W'(stall_max_o) <= stall_sum_o) && (SUM_W'(gap_max_o) <= gap_sum_o)); // R4

endmodule

// File: tb/sim_dma_tput_stats.sv
module sim_dma_tput_stats;
    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned P  = 50;
    localparam int unsigned CW = 6;
    localparam int unsigned SW = $clog2(P) + CW;
    localparam int unsigned EW = $clog2(P + 1);
    localparam longint      LIM = (64'd1 << CW) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic stall = 1'b0;
    logic desc = 1'b0;
    logic          snap_o;
    logic [CW-1:0] s_last, s_max, g_last, g_max;
    logic [SW-1:0] s_sum, g_sum;
    logic [EW-1:0] s_cnt, g_cnt;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dma_tput_stats #(.PERIOD(P), .CNT_W(CW)) u0 (
        .clk(clk), .rst(rst), .stall_i(stall), .desc_i(desc), .snap_o(snap_o),
        .stall_last_o(s_last), .stall_max_o(s_max), .stall_sum_o(s_sum), .stall_cnt_o(s_cnt),
        .gap_last_o(g_last), .gap_max_o(g_max), .gap_sum_o(g_sum), .gap_cnt_o(g_cnt)
    );

    // ---------------- behavioural reference ----------------
    longint m_tick, s_run, g_run;
    bit     s_prev, g_armed, m_fresh;
    longint lv_max[2], lv_sum[2], lv_n[2], lv_last[2];
    longint ro_max[2], ro_sum[2], ro_n[2], ro_last[2];

    always @(posedge clk) begin
        bit     e[2];
        longint v[2];
        bit     close;
        if (rst) begin
            m_tick = 0; s_run = 0; g_run = 0; s_prev = 0; g_armed = 0; m_fresh = 0;
            for (int c = 0; c < 2; c++) begin
                lv_max[c] = 0; lv_sum[c] = 0; lv_n[c] = 0; lv_last[c] = 0;
                ro_max[c] = 0; ro_sum[c] = 0; ro_n[c] = 0; ro_last[c] = 0;
            end
        end else begin
            e[0] = 0; v[0] = 0; e[1] = 0; v[1] = 0;
            if (stall) s_run = (s_run >= LIM) ? LIM : s_run + 1;
            else begin
                if (s_prev) begin e[0] = 1; v[0] = s_run; end
                s_run = 0;
            end
            s_prev = stall;
            if (desc) begin
                if (g_armed) begin e[1] = 1; v[1] = g_run; end
                g_run = 1; g_armed = 1;
            end else if (g_armed) g_run = (g_run >= LIM) ? LIM : g_run + 1;
            close = (m_tick == P - 1);
            for (int c = 0; c < 2; c++) begin
                if (e[c]) begin
                    if (v[c] > lv_max[c]) lv_max[c] = v[c];
                    lv_sum[c] += v[c];
                    lv_n[c] += 1;
                    lv_last[c] = v[c];
                end
                if (close) begin
                    ro_max[c] = lv_max[c]; ro_sum[c] = lv_sum[c]; ro_n[c] = lv_n[c];
                    ro_last[c] = lv_last[c];
                    lv_max[c] = 0; lv_sum[c] = 0; lv_n[c] = 0;
                end
            end
            m_fresh = close;
            m_tick = close ? 0 : m_tick + 1;
        end
    end

    // ---------------- checking ----------------
    int    checks = 0;
    int    errors = 0;
    string phase  = "R9";
    int    cycles = 0;

    task automatic chk(input string req, input string nm, input logic [63:0] act, input longint exp);
        checks++;
        if (act !== 64'(exp)) begin
            errors++;
            $display("FAIL %s (phase %s) %s actual=%0d expected=%0d", req, phase, nm, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R6", "snap_o",       64'(snap_o), longint'(m_fresh));
        chk("R8", "stall_last_o", 64'(s_last), ro_last[0]);
        chk("R4", "stall_max_o",  64'(s_max),  ro_max[0]);
        chk("R5", "stall_sum_o",  64'(s_sum),  ro_sum[0]);
        chk("R5", "stall_cnt_o",  64'(s_cnt),  ro_n[0]);
        chk("R8", "gap_last_o",   64'(g_last), ro_last[1]);
        chk("R4", "gap_max_o",    64'(g_max),  ro_max[1]);
        chk("R5", "gap_sum_o",    64'(g_sum),  ro_sum[1]);
        chk("R5", "gap_cnt_o",    64'(g_cnt),  ro_n[1]);
    endtask

    task automatic step(input bit s, input bit d);
        @(negedge clk);
        compare_all();
        stall = s;
        desc  = d;
    endtask

    // next step() drives the cycle whose period position is t
    task automatic wait_tick(input longint t);
        while (((m_tick + 1) % P) != t) step(0, 0);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000) begin
            errors++;
            $display("FAIL watchdog expired in phase %s", phase);
            finish_run();
        end
    end

    initial begin
        // R9: reset state
        phase = "R9";
        repeat (3) begin
            @(negedge clk);
            compare_all();
        end
        rst = 1'b0;

        // R1: stall runs of several lengths
        phase = "R1";
        step(1, 0); repeat (3) step(0, 0);
        repeat (3) step(1, 0); step(0, 0);
        repeat (7) step(1, 0); repeat (4) step(0, 0);
        repeat (2) step(1, 0); step(0, 0); step(1, 0); step(0, 0);

        // R2: adjacent and spaced descriptors
        phase = "R2";
        step(0, 1); step(0, 1); step(0, 0); step(0, 1);
        repeat (5) step(0, 0); step(0, 1); step(0, 0);

        // R3: intervals longer than the counter range
        phase = "R3";
        repeat (80) step(1, 0); step(0, 0);
        step(0, 1); repeat (90) step(0, 0); step(0, 1); step(0, 0);

        // R10: stall straddling a boundary
        phase = "R10";
        wait_tick(P - 5);
        repeat (10) step(1, 0); step(0, 0);
        wait_tick(P - 3);
        step(0, 1); repeat (6) step(0, 0); step(0, 1);

        // R7: both intervals complete in the closing cycle
        phase = "R7";
        wait_tick(P - 4);
        repeat (3) step(1, 0);
        step(0, 1);
        repeat (3) step(0, 0);
        wait_tick(P - 1);
        step(0, 1);
        repeat (P + 3) step(0, 0);

        // R8: periods without events keep the last value
        phase = "R8";
        repeat (2 * P + 5) step(0, 0);

        // R4 R5 R6: sparse random traffic
        phase = "R4 R5 R6";
        begin
            bit s = 0;
            for (int i = 0; i < 700; i++) begin
                if (($urandom % 5) == 0) s = !s;
                step(s, ($urandom % 6) == 0);
            end
        end

        // R5: dense random traffic
        phase = "R5 dense";
        for (int i = 0; i < 400; i++) step(($urandom % 2) == 1, ($urandom % 2) == 1);

        repeat (P + 2) step(0, 0);
        finish_run();
    end

endmodule